// File: doc/BRIEF.md
# Bidirectional PWM Channel Bank

This block holds a bank of independent channels, each tied to one digital line. A mode bit set per channel makes the line either a pulse-width generator or a pulse-width meter. As a generator, the channel drives the line high for a programmed number of clock ticks, then low for a second programmed number, and repeats. As a meter, the line goes high-impedance (its output enable drops). The channel samples the line on every clock and reports, in ticks, how long the most recent high phase and the most recent low phase lasted.

Host software turns a frequency and duty cycle into tick counts and writes them through a flat register interface. Writes are single-cycle strobes. Reads are combinational from the read address. The host may rewrite the tick counts at any moment while a channel is running. The channel only picks up new counts at the boundary of a full period.

Top module: `pwm_bank`

## Requirements
- R1: The register address is {channel, sel}, with sel in the low 3 bits. Sel 0 is the high-time count and sel 1 is the low-time count, both read/write and CNT_W bits wide. Sel 2 is the measured high period and sel 3 is the measured low period, both read-only. Sel 4 is the mode bit, in bit 0. Each channel keeps its own copy of these registers.
- R2: A mode bit of 0 selects output: lineOe is 1. A mode bit of 1 selects input: lineOe is 0 and lineOut is 0. After reset every mode bit reads 1, and every tick count and every measured value reads 0.
- R3: In output mode, lineOut is high for exactly H clock cycles and then low for exactly L clock cycles, and this repeats. H and L are the high-time and low-time counts latched at the start of the period. The first high phase begins one cycle after the mode bit turns to 0.
- R4: A write to a tick count during a period does not change that period. The new counts apply from the next period start.
- R5: A count of 0 is treated as one tick. If both counts are 0 at a period start, the line stays low and no period begins.
- R6: In input mode the line passes through a two-flop synchronizer. A high or low run length is published only when the edge that ends it arrives. The first partial run after entering input mode is never published.
- R7: A run-length counter in a meter stops at 2^CNT_W-1 instead of wrapping, and that maximum is the value published.
- R8: In input mode the generator is held idle, so lineOut stays 0. In output mode the meter is frozen, so the measured values keep their last contents whatever the line does.
- R9: Writes to sel codes other than 0, 1 and 4 are ignored. Reads of sel codes 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address {channel, sel} |
| wrData | input | CNT_W | Write data |
| rdAddr | input | ADDR_W | Read address {channel, sel} |
| rdData | output | CNT_W | Read data (combinational) |
| lineIn | input | NUM_CH | Sampled level of each line |
| lineOut | output | NUM_CH | Driven level of each line |
| lineOe | output | NUM_CH | Output enable per line (0 = released) |

## Verification
The generator is tested in three ways:
- With an asymmetric high/low pair, to show that the two phases are timed separately.
- With a count rewritten in the middle of a period, which separates a period-boundary update from an immediate one.
- With zero counts, which tells the one-tick rule apart from a held-low idle.

The meter is tested in these ways:
- With two different duty patterns, to show that high and low runs are published independently.
- With a run longer than the counter range on a narrow instance, which shows that the counter stops at its maximum.
- With line activity while the channel is in output mode, which must leave the measured values unchanged.
- With a check before the first complete run, which shows that the partial first run is discarded.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_t;

  typedef struct packed {
    logic load;     // copy staged tick counts into the active pair
    logic restart;  // tick counter back to 1 (first tick of a phase)
    logic advance;  // tick counter +1
    logic measRun;  // meter enabled
  } chanStrobe_t;

  localparam logic [2:0] SEL_HI    = 3'd0;
  localparam logic [2:0] SEL_LO    = 3'd1;
  localparam logic [2:0] SEL_MHI   = 3'd2;
  localparam logic [2:0] SEL_MLO   = 3'd3;
  localparam logic [2:0] SEL_MODE  = 3'd4;
endpackage

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      st,
  input  logic [CNT_W-1:0] stageHi,
  input  logic [CNT_W-1:0] stageLo,
  input  logic             lineIn,
  output logic             hiDone,
  output logic             loDone,
  output logic             stageZero,
  output logic [CNT_W-1:0] measHi,
  output logic [CNT_W-1:0] measLo
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] hiAct, loAct, tickCnt;
  logic [CNT_W-1:0] hiEff, loEff;

  // generator datapath
  assign hiEff     = (hiAct == '0) ? CNT_ONE : hiAct;
  assign loEff     = (loAct == '0) ? CNT_ONE : loAct;
  assign hiDone    = tickCnt >= hiEff;
  assign loDone    = tickCnt >= loEff;
  assign stageZero = (stageHi == '0) && (stageLo == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiAct   <= '0;
      loAct   <= '0;
      tickCnt <= CNT_ONE;
    end else begin
      if (st.load) begin
        hiAct <= stageHi;
        loAct <= stageLo;
      end
      if (st.restart)                      tickCnt <= CNT_ONE;
      else if (st.advance && tickCnt != CNT_MAX) tickCnt <= tickCnt + CNT_ONE;
    end
  end

  // meter datapath
  logic [1:0]       syncQ;
  logic             prevQ, lvl, edgeSeen, armed;
  logic [CNT_W-1:0] runCnt;

  assign lvl      = syncQ[1];
  assign edgeSeen = lvl ^ prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '0;
      prevQ  <= 1'b0;
      armed  <= 1'b0;
      runCnt <= CNT_ONE;
      measHi <= '0;
      measLo <= '0;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      prevQ <= lvl;
      if (st.measRun) begin
        if (edgeSeen) begin
          armed  <= 1'b1;
          runCnt <= CNT_ONE;
          if (armed) begin
            if (prevQ) measHi <= runCnt;
            else       measLo <= runCnt;
          end
        end else if (runCnt != CNT_MAX) begin
          runCnt <= runCnt + CNT_ONE;
        end
      end else begin
        armed <= 1'b0;
      end
    end
  end

  // R4: active counts only move on a period-start load
  a_r4_act_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.load |=> ($stable(hiAct) && $stable(loAct)));
  // R7: a run counter at its maximum stays there
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    (st.measRun && !edgeSeen && runCnt == CNT_MAX) |=> runCnt == CNT_MAX);
  // R6/R8: published values change only on a terminating edge in input mode
  a_r6_publish_edge: assert property (@(posedge clk) disable iff (!rstN)
    !(st.measRun && edgeSeen) |=> ($stable(measHi) && $stable(measLo)));
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeIn,
  input  logic        hiDone,
  input  logic        loDone,
  input  logic        stageZero,
  output chanStrobe_t st,
  output logic        lineHigh
);
  phase_t phase, phaseNxt;

  always_comb begin
    st         = '0;
    st.measRun = modeIn;
    phaseNxt   = phase;
    if (modeIn) begin
      phaseNxt = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (!stageZero) begin
          st.load = 1'b1; st.restart = 1'b1; phaseNxt = PH_HIGH;
        end
        PH_HIGH: if (hiDone) begin
          st.restart = 1'b1; phaseNxt = PH_LOW;
        end else st.advance = 1'b1;
        PH_LOW: if (loDone) begin
          if (stageZero) phaseNxt = PH_IDLE;
          else begin
            st.load = 1'b1; st.restart = 1'b1; phaseNxt = PH_HIGH;
          end
        end else st.advance = 1'b1;
        default: phaseNxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  assign lineHigh = (phase == PH_HIGH);

  // R3: a high phase never ends before its count is reached
  a_r3_no_early_fall: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && !hiDone && !modeIn) |=> phase == PH_HIGH);
  // R8: input mode parks the generator
  a_r8_idle_in_input: assert property (@(posedge clk) disable iff (!rstN)
    modeIn |=> phase == PH_IDLE);
  // R5: both counts zero at a period start keeps the line low
  a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && stageZero) |=> phase == PH_IDLE);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic [NUM_CH-1:0] lineIn,
  output logic [NUM_CH-1:0] lineOut,
  output logic [NUM_CH-1:0] lineOe
);
  logic [CH_W-1:0] wrCh, rdCh;
  logic [2:0]      wrSel, rdSel;
  assign wrCh  = wrAddr[ADDR_W-1:3];
  assign wrSel = wrAddr[2:0];
  assign rdCh  = rdAddr[ADDR_W-1:3];
  assign rdSel = rdAddr[2:0];

  logic [CNT_W-1:0] hiArr   [NUM_CH];
  logic [CNT_W-1:0] loArr   [NUM_CH];
  logic [CNT_W-1:0] mHiArr  [NUM_CH];
  logic [CNT_W-1:0] mLoArr  [NUM_CH];
  logic [NUM_CH-1:0] modeVec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic        hitCh, hiDone, loDone, stageZero, lineHigh;
    chanStrobe_t st;

    assign hitCh = wrEn && (wrCh == CH_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiArr[i]   <= '0;
        loArr[i]   <= '0;
        modeVec[i] <= 1'b1;
      end else if (hitCh) begin
        case (wrSel)
          SEL_HI:   hiArr[i]   <= wrData;
          SEL_LO:   loArr[i]   <= wrData;
          SEL_MODE: modeVec[i] <= wrData[0];
          default: ;
        endcase
      end
    end

    pwm_chan_ctrl u_ctrl (
      .clk(clk), .rstN(rstN), .modeIn(modeVec[i]),
      .hiDone(hiDone), .loDone(loDone), .stageZero(stageZero),
      .st(st), .lineHigh(lineHigh)
    );

    pwm_chan_dp #(.CNT_W(CNT_W)) u_dp (
      .clk(clk), .rstN(rstN), .st(st),
      .stageHi(hiArr[i]), .stageLo(loArr[i]), .lineIn(lineIn[i]),
      .hiDone(hiDone), .loDone(loDone), .stageZero(stageZero),
      .measHi(mHiArr[i]), .measLo(mLoArr[i])
    );

    assign lineOut[i] = lineHigh && !modeVec[i];
    assign lineOe[i]  = !modeVec[i];
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdCh == CH_W'(c)) begin
        case (rdSel)
          SEL_HI:   rdData = hiArr[c];
          SEL_LO:   rdData = loArr[c];
          SEL_MHI:  rdData = mHiArr[c];
          SEL_MLO:  rdData = mLoArr[c];
          SEL_MODE: rdData = CNT_W'(modeVec[c]);
          default:  rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int NCH = 16;
  localparam int CW  = 32;
  localparam int AW  = 7;
  localparam int NW  = 6;   // narrow instance counter width

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;    // 50 MHz

  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [CW-1:0] wrData = '0, rdData;
  logic [NCH-1:0] lineIn = '0, lineOut, lineOe;

  logic [3:0]    rdAddr2 = '0;
  logic [NW-1:0] rdData2;
  logic [1:0]    lineIn2 = '0, lineOut2, lineOe2;

  pwm_bank #(.NUM_CH(NCH), .CNT_W(CW)) u_pwm_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .lineIn(lineIn), .lineOut(lineOut), .lineOe(lineOe));

  pwm_bank #(.NUM_CH(2), .CNT_W(NW)) u_pwm_bank_narrow (
    .clk(clk), .rstN(rstN), .wrEn(1'b0), .wrAddr(4'd0), .wrData('0),
    .rdAddr(rdAddr2), .rdData(rdData2), .lineIn(lineIn2), .lineOut(lineOut2), .lineOe(lineOe2));

  int nRun = 0, nFail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input int ch, input int sel);
    return {ch[3:0], sel[2:0]};
  endfunction

  task automatic wr(input int ch, input int sel, input logic [CW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = adr(ch, sel); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkRd(input int ch, input int sel, input longint exp, input string tag);
    @(negedge clk);
    rdAddr = adr(ch, sel);
    #1;
    check(rdData == exp, tag, rdData, exp);
  endtask

  task automatic drivePat(input int ch, input int h, input int l, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); lineIn[ch] = 1'b1;
      repeat (h - 1) @(negedge clk);
      @(negedge clk); lineIn[ch] = 1'b0;
      repeat (l - 1) @(negedge clk);
    end
  endtask

  // scoreboard: expected run lengths of the monitored output line
  typedef struct { logic lvl; int len; } runItem_t;
  runItem_t expQ[$];
  int  monCh = 0, popCnt = 0, runLen = 0;
  bit  monOn = 0, started = 0, skip = 0;
  logic lastLvl = 1'b0;

  task automatic push(input logic lv, input int len);
    runItem_t it;
    it.lvl = lv; it.len = len;
    expQ.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!monOn) started = 0;
    else if (!started) begin
      started = 1; skip = 1; lastLvl = lineOut[monCh]; runLen = 1;
    end else if (lineOut[monCh] == lastLvl) begin
      runLen++;
    end else begin
      if (skip) skip = 0;
      else if (expQ.size() > 0) begin
        runItem_t e;
        e = expQ.pop_front();
        popCnt++;
        check(e.lvl == lastLvl && e.len == runLen, "R3/R4/R5 run length", runLen, e.len);
      end
      lastLvl = lineOut[monCh]; runLen = 1;
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    check(lineOe == '0 && lineOut == '0, "R2 reset lines released", lineOe, 0);
    chkRd(0, 4, 1, "R2 reset mode is input");
    chkRd(5, 0, 0, "R2 reset high count");
    chkRd(3, 2, 0, "R2 reset measured high");

    // R1 register access per channel
    wr(7, 0, 32'h1234_5678);
    wr(8, 1, 32'd99);
    chkRd(7, 0, 32'h1234_5678, "R1 high count readback");
    chkRd(8, 1, 99, "R1 low count readback");
    chkRd(8, 0, 0, "R1 channels independent");

    // R9 unused selects
    wr(7, 5, 32'hFFFF);
    wr(7, 2, 32'd55);
    chkRd(7, 5, 0, "R9 unused read zero");
    chkRd(7, 2, 0, "R9 measured not writable");
    chkRd(7, 0, 32'h1234_5678, "R9 write ignored");

    // R3 + R4: generator on channel 0, counts changed mid-period
    wr(0, 0, 3); wr(0, 1, 5);
    monCh = 0; popCnt = 0;
    for (int k = 0; k < 3; k++) begin push(1'b1, 3); push(1'b0, 5); end
    for (int k = 0; k < 2; k++) begin push(1'b1, 2); push(1'b0, 4); end
    monOn = 1;
    wr(0, 4, 0);
    check(lineOe[0] == 1'b1, "R2 output enable in output mode", lineOe[0], 1);
    wait (popCnt == 4);
    wr(0, 0, 2); wr(0, 1, 4);        // lands inside the third period (R4)
    wait (expQ.size() == 0);
    monOn = 0;
    @(negedge clk);

    // R5: zero counts count as one tick
    wr(2, 0, 0); wr(2, 1, 2);
    monCh = 2; popCnt = 0;
    for (int k = 0; k < 3; k++) begin push(1'b1, 1); push(1'b0, 2); end
    monOn = 1;
    wr(2, 4, 0);
    wait (expQ.size() == 0);
    monOn = 0;
    @(negedge clk);

    // R5: both zero keeps the line low
    wr(1, 4, 0);
    begin
      bit anyHigh = 0;
      repeat (20) begin @(negedge clk); if (lineOut[1]) anyHigh = 1; end
      check(!anyHigh && lineOe[1], "R5 both zero held low", anyHigh, 0);
    end

    // R8: returning to input mode stops the generator
    wr(4, 0, 2); wr(4, 1, 2); wr(4, 4, 0);
    repeat (10) @(negedge clk);
    wr(4, 4, 1);
    begin
      bit anyHigh = 0;
      repeat (12) begin @(negedge clk); if (lineOut[4] || lineOe[4]) anyHigh = 1; end
      check(!anyHigh, "R8 input mode releases line", anyHigh, 0);
    end

    // R6: meter on channel 3
    drivePat(3, 7, 4, 3);
    repeat (5) @(negedge clk);
    chkRd(3, 2, 7, "R6 measured high 7");
    chkRd(3, 3, 4, "R6 measured low 4");
    drivePat(3, 3, 12, 3);
    repeat (5) @(negedge clk);
    chkRd(3, 2, 3, "R6 measured high 3");
    chkRd(3, 3, 12, "R6 measured low 12");

    // R8: meter frozen in output mode
    wr(3, 4, 0);
    drivePat(3, 5, 5, 3);
    repeat (5) @(negedge clk);
    chkRd(3, 2, 3, "R8 frozen high");
    chkRd(3, 3, 12, "R8 frozen low");

    // R6 first partial run discarded, R7 saturation (narrow instance)
    repeat (5) @(negedge clk);
    lineIn2[0] = 1'b1;
    repeat (40) @(negedge clk);
    rdAddr2 = 4'd3; #1;
    check(rdData2 == 0, "R6 partial first run not published", rdData2, 0);
    repeat (60) @(negedge clk);
    lineIn2[0] = 1'b0;
    repeat (10) @(negedge clk);
    lineIn2[0] = 1'b1;
    repeat (3) @(negedge clk);
    lineIn2[0] = 1'b0;
    repeat (6) @(negedge clk);
    rdAddr2 = 4'd2; #1;
    check(rdData2 == 3, "R7 short high after saturation", rdData2, 3);
    rdAddr2 = 4'd3; #1;
    check(rdData2 == 10, "R6 narrow low run", rdData2, 10);
    lineIn2[0] = 1'b1;
    repeat (100) @(negedge clk);
    lineIn2[0] = 1'b0;
    repeat (6) @(negedge clk);
    rdAddr2 = 4'd2; #1;
    check(rdData2 == 63, "R7 saturated high run", rdData2, 63);

    finishRun();
  end
endmodule